// File: doc/BRIEF.md
# Phasing Sideband Selector

This block takes a complex baseband stream (12-bit I and Q samples with a valid strobe) and produces one real 12-bit audio sample per input sample. It keeps one sideband and cancels the other. The I arm goes through an antisymmetric FIR phase shifter that rotates every component by a quarter turn. The Q arm goes through a circular-buffer delay whose length equals the shifter's group delay. A combiner then adds the two arms or subtracts one from the other, halves the result and clips it. A select bit, captured together with each sample, picks which sideband survives. Content near DC and near half the sample rate is attenuated by the phase shifter. At 50 kHz sampling this means that roughly the lowest 500 Hz is not recovered.

The filter takes advantage of its coefficient structure. Every tap at an even distance from the centre is zero, and each tap at an odd distance k has the opposite sign to its mirror tap. The mirrored samples are therefore subtracted first, and each odd distance needs only one multiplier. The block sits between a decimator and an audio low-pass stage, and it runs one sample per strobe.

Top module: `ssb_phasing_selector`

## Requirements
- R1: While `rst_n` is low and directly after reset, `out_valid` is 0 and `out_audio` is 0.
- R2: The first DLY (34) accepted samples after reset produce no `out_valid`. Every accepted sample from index DLY onward (counting from 0) produces exactly one `out_valid` pulse.
- R3: For an accepted sample, `out_valid` is high for one cycle. That cycle is the second clock cycle after the cycle in which `in_valid` was high.
- R4: The shifted I arm for sample n is H(n) = floor( sum over odd k, 1 <= k <= DLY, of c_k * (I[n-DLY-k] - I[n-DLY+k]) / 2^11 ). The coefficients are c_k = floor((1304 + floor(k/2)) / k). I samples from before reset count as 0.
- R5: The Q arm for sample n is Q[n-DLY]. For example, after reset, with all I samples 0, Q[0]=1000 and later Q samples 0, sample DLY gives 500 when the select bit is 0 and -500 when it is 1.
- R6: With select 0 the output is floor((H+Q)/2). With select 1 it is floor((H-Q)/2).
- R7: Results above 2047 come out as 2047 and results below -2048 come out as -2048.
- R8: Clock cycles with `in_valid` low advance neither arm, raise no `out_valid` and leave `out_audio` unchanged.
- R9: The select bit is taken in the same cycle as its sample. A change of `sel_lsb` in later cycles does not alter that sample's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe for `in_i`, `in_q`, `sel_lsb` |
| in_i | input | 12 | In-phase sample, two's complement |
| in_q | input | 12 | Quadrature sample, two's complement |
| sel_lsb | input | 1 | 0 = sum arms, 1 = difference of arms |
| out_valid | output | 1 | One-cycle strobe for `out_audio` |
| out_audio | output | 12 | Demodulated audio sample, two's complement |

## Verification
Clipping is the hardest case to reach from the ports. It needs the 33 newer and the 33 older taps around the centre of the I history to sit at opposite full-scale values, so the stimulus holds I at +2047 for a long run and then at -2048 for exactly DLY samples, and then repeats this with the signs swapped. The Q alignment is separated from the I arm by a reset followed by an all-zero I stream that carries a single Q impulse. The select bit is flipped right after each strobe so that a late capture of the select bit would show up.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  // Quarter-turn phase shifter coefficient for odd tap distance k = 2*idx+1,
  // peak value at k = 1, rounded to nearest.
  function automatic int odd_coef(input int idx, input int peak);
    int k;
    k = 2 * idx + 1;
    return (peak + k / 2) / k;
  endfunction
endpackage

// File: rtl/sbs_tapline.sv
module sbs_tapline #(
  parameter int DW  = 12,
  parameter int DLY = 34
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic signed [DW-1:0]  din,
  output logic [((DLY+1)/2)*DW-1:0] older_flat,
  output logic [((DLY+1)/2)*DW-1:0] newer_flat
);
  localparam int NODD = (DLY + 1) / 2;
  localparam int KMAX = 2 * NODD - 1;
  localparam int LEN  = DLY + KMAX + 1;

  logic [DW-1:0] sr     [LEN];
  logic [DW-1:0] sr_nxt [LEN];

  always_comb begin
    for (int j = 0; j < LEN; j++) sr_nxt[j] = sr[j];
    if (en) begin
      sr_nxt[0] = din;
      for (int j = 1; j < LEN; j++) sr_nxt[j] = sr[j-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < LEN; j++) sr[j] <= '0;
    end else begin
      for (int j = 0; j < LEN; j++) sr[j] <= sr_nxt[j];
    end
  end

  for (genvar g = 0; g < NODD; g++) begin : g_pair
    assign older_flat[g*DW +: DW] = sr[DLY + 2*g + 1];
    assign newer_flat[g*DW +: DW] = sr[DLY - 2*g - 1];
  end
endmodule

// File: rtl/sbs_hilbert.sv
module sbs_hilbert #(
  parameter int DW    = 12,
  parameter int DLY   = 34,
  parameter int CW    = 12,
  parameter int CFRAC = 11,
  parameter int PEAK  = 1304,
  parameter int ACCW  = 32
) (
  input  logic [((DLY+1)/2)*DW-1:0] older_flat,
  input  logic [((DLY+1)/2)*DW-1:0] newer_flat,
  output logic signed [ACCW-1:0]    hout
);
  import sbs_pkg::*;
  localparam int NODD = (DLY + 1) / 2;

  logic signed [ACCW-1:0] prod [NODD];
  logic signed [ACCW-1:0] acc;

  for (genvar g = 0; g < NODD; g++) begin : g_tap
    localparam logic signed [CW-1:0] COEF = CW'(odd_coef(g, PEAK));
    logic signed [DW-1:0]   x_old, x_new;
    logic signed [DW:0]     diff;
    logic signed [ACCW-1:0] dext, cext;
    assign x_old   = older_flat[g*DW +: DW];
    assign x_new   = newer_flat[g*DW +: DW];
    // mirrored taps carry opposite signs: pre-subtract, one multiply per pair
    assign diff    = (DW+1)'(x_old) - (DW+1)'(x_new);
    assign dext    = ACCW'(diff);
    assign cext    = ACCW'(COEF);
    assign prod[g] = dext * cext;
  end

  always_comb begin
    acc = '0;
    for (int j = 0; j < NODD; j++) acc = acc + prod[j];
    hout = acc >>> CFRAC;
  end
endmodule

// File: rtl/sbs_qdelay.sv
module sbs_qdelay #(
  parameter int DW    = 12,
  parameter int DEPTH = 34
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr, ptr_nxt;
  logic signed [DW-1:0] dout_nxt;

  always_comb begin
    ptr_nxt  = ptr;
    dout_nxt = dout;
    if (en) begin
      dout_nxt = mem[ptr];
      ptr_nxt  = (ptr == PW'(DEPTH - 1)) ? '0 : ptr + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      dout <= '0;
    end else begin
      ptr  <= ptr_nxt;
      dout <= dout_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (en) mem[ptr] <= din;
  end

  // R5
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < PW'(DEPTH));
endmodule

// File: rtl/sbs_combine.sv
module sbs_combine #(
  parameter int DW = 12,
  parameter int HW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 sel,
  input  logic signed [HW-1:0] hval,
  input  logic signed [DW-1:0] qval,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_audio
);
  localparam int SW = HW + 1;
  localparam logic signed [SW-1:0] HI = SW'((2 ** (DW - 1)) - 1);
  localparam logic signed [SW-1:0] LO = -HI - SW'(1);

  logic signed [SW-1:0] sum, half;
  logic signed [DW-1:0] audio_nxt;
  logic                 valid_nxt;

  always_comb begin
    sum       = sel ? (SW'(hval) - SW'(qval)) : (SW'(hval) + SW'(qval));
    half      = sum >>> 1;
    valid_nxt = en;
    audio_nxt = out_audio;
    if (en) begin
      if (half > HI)      audio_nxt = HI[DW-1:0];
      else if (half < LO) audio_nxt = LO[DW-1:0];
      else                audio_nxt = half[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_audio <= '0;
    end else begin
      out_valid <= valid_nxt;
      out_audio <= audio_nxt;
    end
  end

  // R7
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && half > HI) |=> (out_audio == HI[DW-1:0]));
  // R7
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && half < LO) |=> (out_audio == LO[DW-1:0]));
endmodule

// File: rtl/ssb_phasing_selector.sv
module ssb_phasing_selector #(
  parameter int DW    = 12,
  parameter int DLY   = 34,
  parameter int CW    = 12,
  parameter int CFRAC = 11,
  parameter int PEAK  = 1304
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic                 sel_lsb,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_audio
);
  localparam int NODD = (DLY + 1) / 2;
  localparam int ACCW = DW + 1 + CW + $clog2(NODD + 1) + 1;
  localparam int CNTW = $clog2(DLY + 1);

  logic [NODD*DW-1:0]     older_flat, newer_flat;
  logic signed [ACCW-1:0] hval;
  logic signed [DW-1:0]   qval;
  logic [CNTW-1:0]        cnt, cnt_nxt;
  logic                   vld_d, vld_nxt, sel_d, sel_nxt;

  always_comb begin
    cnt_nxt = cnt;
    sel_nxt = sel_d;
    vld_nxt = 1'b0;
    if (in_valid) begin
      sel_nxt = sel_lsb;
      vld_nxt = (cnt == CNTW'(DLY));
      if (cnt != CNTW'(DLY)) cnt_nxt = cnt + CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      vld_d <= 1'b0;
      sel_d <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      vld_d <= vld_nxt;
      sel_d <= sel_nxt;
    end
  end

  sbs_tapline #(.DW(DW), .DLY(DLY)) u_tap (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .din(in_i),
    .older_flat(older_flat), .newer_flat(newer_flat)
  );

  sbs_hilbert #(.DW(DW), .DLY(DLY), .CW(CW), .CFRAC(CFRAC), .PEAK(PEAK), .ACCW(ACCW)) u_hil (
    .older_flat(older_flat), .newer_flat(newer_flat), .hout(hval)
  );

  sbs_qdelay #(.DW(DW), .DEPTH(DLY)) u_qd (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .din(in_q), .dout(qval)
  );

  sbs_combine #(.DW(DW), .HW(ACCW)) u_cmb (
    .clk(clk), .rst_n(rst_n), .en(vld_d), .sel(sel_d),
    .hval(hval), .qval(qval), .out_valid(out_valid), .out_audio(out_audio)
  );

  // R3
  out_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));
  // R2
  primed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(cnt, 2) == CNTW'(DLY)));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_audio));
endmodule

// File: tb/sim_ssb_phasing_selector.sv
module sim_ssb_phasing_selector;
  localparam int DLY = 34;
  localparam int NODD = (DLY + 1) / 2;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [11:0] in_i, in_q;
  logic sel_lsb;
  logic out_valid;
  logic signed [11:0] out_audio;

  always #10 clk = ~clk;

  ssb_phasing_selector u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .sel_lsb(sel_lsb), .out_valid(out_valid), .out_audio(out_audio)
  );

  // stimulus: {I, Q, select}
  localparam logic [24:0] VEC [24] = '{
    {12'h3A0, 12'hF10, 1'b0}, {12'hC40, 12'h120, 1'b0}, {12'h7FF, 12'h800, 1'b1},
    {12'h800, 12'h7FF, 1'b1}, {12'h001, 12'hFFF, 1'b0}, {12'h255, 12'h4D2, 1'b1},
    {12'hABC, 12'h321, 1'b0}, {12'h100, 12'h100, 1'b1}, {12'hF00, 12'hF00, 1'b0},
    {12'h000, 12'h7FF, 1'b0}, {12'h000, 12'h800, 1'b1}, {12'h5A5, 12'hA5A, 1'b0},
    {12'h123, 12'h456, 1'b1}, {12'hEDC, 12'hBA9, 1'b1}, {12'h400, 12'hC00, 1'b0},
    {12'h7F0, 12'h00F, 1'b0}, {12'h80F, 12'hFF0, 1'b1}, {12'h2AA, 12'hD55, 1'b0},
    {12'h600, 12'h200, 1'b1}, {12'hA00, 12'hE00, 1'b0}, {12'h0F0, 12'hF0F, 1'b1},
    {12'h333, 12'hCCC, 1'b0}, {12'h777, 12'h888, 1'b1}, {12'hFFF, 12'h001, 1'b0}
  };

  int tests = 0;
  int fails = 0;
  int nsmp  = 0;
  int hist_i [0:1023];
  int hist_q [0:1023];
  int last_out;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int i_at(input int j);
    return (j < 0) ? 0 : hist_i[j];
  endfunction

  // model from R4, R5, R6, R7
  function automatic int model(input int n, input bit s);
    int acc, h, sum, half;
    acc = 0;
    for (int g = 0; g < NODD; g++) begin
      int k, c;
      k = 2 * g + 1;
      c = (1304 + k / 2) / k;
      acc += c * (i_at(n - DLY - k) - i_at(n - DLY + k));
    end
    h = acc >>> 11;
    sum = s ? (h - hist_q[n - DLY]) : (h + hist_q[n - DLY]);
    half = sum >>> 1;
    if (half > 2047) half = 2047;
    if (half < -2048) half = -2048;
    return half;
  endfunction

  task automatic apply(input int iv, input int qv, input bit s);
    int exp, prev;
    hist_i[nsmp] = iv;
    hist_q[nsmp] = qv;
    prev = int'(out_audio);
    @(negedge clk);
    in_i = 12'(iv); in_q = 12'(qv); sel_lsb = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    sel_lsb = ~s; // R9: late change of the select bit must not matter
    in_i = 12'(~iv); in_q = 12'(~qv);
    chk(out_valid == 1'b0, "R3 no strobe one cycle after sample", int'(out_valid), 0);
    @(negedge clk);
    if (nsmp >= DLY) begin
      exp = model(nsmp, s);
      chk(out_valid == 1'b1, "R2/R3 strobe for primed sample", int'(out_valid), 1);
      chk(int'(out_audio) == exp, "R4/R6/R9 audio value", int'(out_audio), exp);
    end else begin
      chk(out_valid == 1'b0, "R2 no strobe while priming", int'(out_valid), 0);
      chk(int'(out_audio) == prev, "R2 audio unchanged while priming", int'(out_audio), prev);
    end
    last_out = int'(out_audio);
    @(negedge clk);
    chk(out_valid == 1'b0 && int'(out_audio) == last_out, "R8 idle cycle holds output",
        int'(out_audio), last_out);
    nsmp++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0; sel_lsb = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid low in reset", int'(out_valid), 0);
    chk(int'(out_audio) == 0, "R1 audio zero in reset", int'(out_audio), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && int'(out_audio) == 0, "R1 state after reset", int'(out_audio), 0);
    nsmp = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0; sel_lsb = 1'b0;
    do_reset();

    // priming with a varied pattern (R2), then table walk (R4, R6, R9)
    for (int j = 0; j < DLY; j++) apply(((j * 397) % 3000) - 1500, ((j * 211) % 2600) - 1300, j[0]);
    for (int v = 0; v < 24; v++)
      apply(int'($signed(VEC[v][24:13])), int'($signed(VEC[v][12:1])), VEC[v][0]);

    // R7 positive clip: older taps full positive, newer taps full negative
    for (int j = 0; j < 70; j++) apply(2047, 0, 1'b0);
    for (int j = 0; j < DLY; j++) apply(-2048, 0, 1'b0);
    chk(last_out == 2047, "R7 clip high", last_out, 2047);
    // R7 negative clip
    for (int j = 0; j < 70; j++) apply(-2048, 0, 1'b0);
    for (int j = 0; j < DLY; j++) apply(2047, 0, 1'b0);
    chk(last_out == -2048, "R7 clip low", last_out, -2048);

    // R5 Q alignment after a fresh reset, I held at zero
    do_reset();
    apply(0, 1000, 1'b0);
    for (int j = 1; j < DLY; j++) apply(0, 0, 1'b0);
    apply(0, 0, 1'b0);
    chk(last_out == 500, "R5 Q impulse delay, sum", last_out, 500);
    apply(0, 0, 1'b1);
    chk(last_out == 0, "R5 Q impulse gone next sample", last_out, 0);

    do_reset();
    apply(0, 1000, 1'b1);
    for (int j = 1; j < DLY; j++) apply(0, 0, 1'b0);
    apply(0, 0, 1'b1);
    chk(last_out == -500, "R5 Q impulse delay, difference", last_out, -500);

    finish_run();
  end
endmodule